// File: doc/BRIEF.md
# Hardware Exception Syndrome Unit

This unit sits beside a processor's load/store path and floating-point unit and turns their fault conditions into three things an exception handler reads: a captured fault address, a syndrome word that encodes the cause and access details, and a one-cycle exception request. It watches four sources: misaligned data accesses, accesses outside a stack window, instruction-fetch and data bus errors, and floating-point exception flags.

Each source is qualified differently. A misaligned access is always recorded, but it requests an exception only while the global exception enable is set. A stack-window violation always records and always requests. A bus error is ignored entirely while exceptions are disabled; otherwise its address is captured and its syndrome and request also depend on a per-bus configuration enable. Floating-point flags always accumulate into sticky status bits. They raise an exception only when the floating-point configuration enable and the global enable are both set.

When several sources fire in the same cycle, one winner is chosen by fixed priority and only that winner updates the address and syndrome. The vectoring logic and pipeline flush that consume the request live outside this block.

Top module: `fault_syndrome_unit`

## Requirements
- R1: After synchronous reset `exc_addr`, `exc_syn`, `fpu_status` and `exc_req` are all zero.
- R2: An access with `acc_valid` high whose address low bits ANDed with `acc_mask` are non-zero is misaligned. One cycle later `exc_addr` holds the address and `exc_syn` holds cause 1 in bits 4:0, `acc_rd` in bits 9:5, `acc_write` in bit 10, and a 1 in bit 11 when `acc_mask` is 3 (word), 0 when it is 1 (halfword). An aligned access changes nothing.
- R3: A misaligned access records the address and syndrome whatever `exc_enable` is. `exc_req` pulses only when `exc_enable` is 1.
- R4: With `stk_check` high, an `acc_addr` strictly below `stk_lo` or strictly above `stk_hi` (unsigned) is a violation. One cycle later the address is captured, `exc_syn` equals 7 and `exc_req` pulses, regardless of `exc_enable`. An address equal to either limit is not a violation.
- R5: While `exc_enable` is 0, a bus error changes neither `exc_addr` nor `exc_syn` and raises no request.
- R6: While `exc_enable` is 1, a bus error captures `berr_addr`. If `berr_fetch` is 1 and `cfg_ibus_exc` is 1, the syndrome becomes 2 and a request pulses. If `berr_fetch` is 0 and `cfg_dbus_exc` is 1, the syndrome becomes 3 and a request pulses. With the matching configuration enable at 0, only the address is captured.
- R7: When `fpu_valid` is high, each set bit of `fpu_flags` sets the matching bit of `fpu_status`: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow. The bits stay set until reset, and flags with `fpu_valid` low are ignored.
- R8: A floating-point event with at least one flag set, `cfg_fpu_exc` 1 and `exc_enable` 1 sets `exc_syn` to 6 and pulses `exc_req`, leaving `exc_addr` unchanged. Otherwise it changes neither `exc_syn` nor `exc_req`.
- R9: When sources fire in the same cycle, only the highest updates address and syndrome, in the order stack violation, misaligned access, bus error, floating-point. Sticky flags still accumulate.
- R10: `exc_req` is high for exactly one cycle per recorded fault that requests. Address and syndrome hold their values in cycles without a recorded fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Load/store access present this cycle |
| acc_addr | input | ADDR_W | Access address (also checked against the stack window) |
| acc_mask | input | 2 | Alignment mask: 3 word, 1 halfword, 0 byte |
| acc_write | input | 1 | Access is a store |
| acc_rd | input | 5 | Register index of the access |
| stk_check | input | 1 | Apply stack-window check to `acc_addr` |
| stk_lo | input | ADDR_W | Lowest legal stack address |
| stk_hi | input | ADDR_W | Highest legal stack address |
| berr_valid | input | 1 | Bus error strobe |
| berr_fetch | input | 1 | Bus error came from an instruction fetch |
| berr_addr | input | ADDR_W | Address of the failing bus transfer |
| fpu_valid | input | 1 | Floating-point flags valid this cycle |
| fpu_flags | input | 4 | Invalid, divide-by-zero, overflow, underflow |
| exc_enable | input | 1 | Global exception enable |
| cfg_ibus_exc | input | 1 | Instruction bus errors may raise exceptions |
| cfg_dbus_exc | input | 1 | Data bus errors may raise exceptions |
| cfg_fpu_exc | input | 1 | Floating-point flags may raise exceptions |
| exc_addr | output | ADDR_W | Captured fault address |
| exc_syn | output | 12 | Syndrome word |
| fpu_status | output | 4 | Sticky floating-point flags |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The assertions check every cycle that a stack violation always yields a request with cause 7, and that a misaligned access not pre-empted by a stack violation captures its address and cause. They also check that a misaligned access with exceptions disabled raises no request and that a cycle with exceptions off and no access leaves the address and syndrome untouched. Two further properties check that sticky flags never clear and that every request traces back to a source strobe one cycle earlier. The full syndrome packing of register index, direction and size, the per-bus configuration gating, the exact limit boundaries and the priority outcomes of simultaneous sources are shown only by the bench's directed scenarios.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    // syndrome layout
    localparam int SYN_W    = 12;
    localparam int CAUSE_W  = 5;
    localparam int RIDX_W   = 5;
    localparam int RIDX_LSB = 5;
    localparam int DIR_BIT  = 10;
    localparam int SIZE_BIT = 11;

    localparam int MASK_W   = 2;
    localparam int FLAG_N   = 4;

    // source slots, index order is priority order (0 highest)
    localparam int NSRC      = 4;
    localparam int SLOT_STK  = 0;
    localparam int SLOT_UNAL = 1;
    localparam int SLOT_BUS  = 2;
    localparam int SLOT_FPU  = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 5'd0,
        CAUSE_UNALIGN = 5'd1,
        CAUSE_IBUS    = 5'd2,
        CAUSE_DBUS    = 5'd3,
        CAUSE_DIVZERO = 5'd5,
        CAUSE_FPU     = 5'd6,
        CAUSE_STACK   = 5'd7
    } cause_e;

    typedef struct packed {
        logic             hit;       // source fired and competes
        logic             set_addr;  // winner loads the address register
        logic             set_syn;   // winner loads the syndrome
        logic             raise;     // winner requests an exception
        logic             addr_bus;  // address comes from the bus error port
        logic [SYN_W-1:0] syn;
    } fault_t;

    function automatic logic [SYN_W-1:0] pack_syn(
        input cause_e            cause,
        input logic              is_store,
        input logic [RIDX_W-1:0] ridx,
        input logic              is_word
    );
        logic [SYN_W-1:0] s;
        s                       = '0;
        s[CAUSE_W-1:0]          = cause;
        s[RIDX_LSB +: RIDX_W]   = ridx;
        s[DIR_BIT]              = is_store;
        s[SIZE_BIT]             = is_word;
        return s;
    endfunction

endpackage

// File: rtl/fsu_fault_detect.sv
module fsu_fault_detect
    import fsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                     acc_valid,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [MASK_W-1:0]        acc_mask,
    input  logic                     acc_write,
    input  logic [RIDX_W-1:0]        acc_rd,
    input  logic                     stk_check,
    input  logic [ADDR_W-1:0]        stk_lo,
    input  logic [ADDR_W-1:0]        stk_hi,
    input  logic                     berr_valid,
    input  logic                     berr_fetch,
    input  logic                     fpu_valid,
    input  logic [FLAG_N-1:0]        fpu_flags,
    input  logic                     exc_enable,
    input  logic                     cfg_ibus_exc,
    input  logic                     cfg_dbus_exc,
    input  logic                     cfg_fpu_exc,
    output fault_t [NSRC-1:0]        faults
);

    logic out_of_window;
    logic misaligned;
    logic is_word;
    logic bus_cfg_ok;

    assign out_of_window = (acc_addr < stk_lo) || (acc_addr > stk_hi);
    assign misaligned    = |(acc_addr[MASK_W-1:0] & acc_mask);
    assign is_word       = (acc_mask == {MASK_W{1'b1}});
    assign bus_cfg_ok    = berr_fetch ? cfg_ibus_exc : cfg_dbus_exc;

    always_comb begin
        faults = '0;

        faults[SLOT_STK].hit      = stk_check && out_of_window;
        faults[SLOT_STK].set_addr = 1'b1;
        faults[SLOT_STK].set_syn  = 1'b1;
        faults[SLOT_STK].raise    = 1'b1;
        faults[SLOT_STK].syn      = pack_syn(CAUSE_STACK, 1'b0, '0, 1'b0);

        faults[SLOT_UNAL].hit      = acc_valid && misaligned;
        faults[SLOT_UNAL].set_addr = 1'b1;
        faults[SLOT_UNAL].set_syn  = 1'b1;
        faults[SLOT_UNAL].raise    = exc_enable;
        faults[SLOT_UNAL].syn      = pack_syn(CAUSE_UNALIGN, acc_write, acc_rd, is_word);

        faults[SLOT_BUS].hit      = berr_valid && exc_enable;
        faults[SLOT_BUS].set_addr = 1'b1;
        faults[SLOT_BUS].set_syn  = bus_cfg_ok;
        faults[SLOT_BUS].raise    = bus_cfg_ok;
        faults[SLOT_BUS].addr_bus = 1'b1;
        faults[SLOT_BUS].syn      = pack_syn(berr_fetch ? CAUSE_IBUS : CAUSE_DBUS,
                                             1'b0, '0, 1'b0);

        faults[SLOT_FPU].hit     = fpu_valid && (|fpu_flags) && cfg_fpu_exc && exc_enable;
        faults[SLOT_FPU].set_syn = 1'b1;
        faults[SLOT_FPU].raise   = 1'b1;
        faults[SLOT_FPU].syn     = pack_syn(CAUSE_FPU, 1'b0, '0, 1'b0);
    end

endmodule

// File: rtl/fsu_prio_sel.sv
module fsu_prio_sel
    import fsu_pkg::*;
(
    input  fault_t [NSRC-1:0] faults,
    output fault_t            winner
);

    // scan from lowest to highest priority so the highest hit is kept last
    always_comb begin
        winner = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (faults[i].hit) begin
                winner = faults[i];
            end
        end
    end

endmodule

// File: rtl/fsu_fpu_sticky.sv
module fsu_fpu_sticky
    import fsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fpu_valid,
    input  logic [FLAG_N-1:0] fpu_flags,
    output logic [FLAG_N-1:0] status
);

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (fpu_valid && fpu_flags[g]) begin
                bit_q <= 1'b1;
            end
        end
        assign status[g] = bit_q;
    end

endmodule

// File: rtl/fault_syndrome_unit.sv
module fault_syndrome_unit
    import fsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_mask,
    input  logic              acc_write,
    input  logic [4:0]        acc_rd,
    input  logic              stk_check,
    input  logic [ADDR_W-1:0] stk_lo,
    input  logic [ADDR_W-1:0] stk_hi,
    input  logic              berr_valid,
    input  logic              berr_fetch,
    input  logic [ADDR_W-1:0] berr_addr,
    input  logic              fpu_valid,
    input  logic [3:0]        fpu_flags,
    input  logic              exc_enable,
    input  logic              cfg_ibus_exc,
    input  logic              cfg_dbus_exc,
    input  logic              cfg_fpu_exc,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [11:0]       exc_syn,
    output logic [3:0]        fpu_status,
    output logic              exc_req
);

    fault_t [NSRC-1:0] faults;
    fault_t            winner;

    logic [ADDR_W-1:0] addr_q;
    logic [SYN_W-1:0]  syn_q;
    logic              req_q;

    fsu_fault_detect #(.ADDR_W(ADDR_W)) detect_i (
        .acc_valid    (acc_valid),
        .acc_addr     (acc_addr),
        .acc_mask     (acc_mask),
        .acc_write    (acc_write),
        .acc_rd       (acc_rd),
        .stk_check    (stk_check),
        .stk_lo       (stk_lo),
        .stk_hi       (stk_hi),
        .berr_valid   (berr_valid),
        .berr_fetch   (berr_fetch),
        .fpu_valid    (fpu_valid),
        .fpu_flags    (fpu_flags),
        .exc_enable   (exc_enable),
        .cfg_ibus_exc (cfg_ibus_exc),
        .cfg_dbus_exc (cfg_dbus_exc),
        .cfg_fpu_exc  (cfg_fpu_exc),
        .faults       (faults)
    );

    fsu_prio_sel prio_i (
        .faults (faults),
        .winner (winner)
    );

    fsu_fpu_sticky sticky_i (
        .clk       (clk),
        .rst       (rst),
        .fpu_valid (fpu_valid),
        .fpu_flags (fpu_flags),
        .status    (fpu_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            syn_q  <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= winner.hit && winner.raise;
            if (winner.hit && winner.set_addr) begin
                addr_q <= winner.addr_bus ? berr_addr : acc_addr;
            end
            if (winner.hit && winner.set_syn) begin
                syn_q <= winner.syn;
            end
        end
    end

    assign exc_addr = addr_q;
    assign exc_syn  = syn_q;
    assign exc_req  = req_q;

endmodule

// File: rtl/fault_syndrome_unit_chk.sv
module fault_syndrome_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_mask,
    input logic              stk_check,
    input logic [ADDR_W-1:0] stk_lo,
    input logic [ADDR_W-1:0] stk_hi,
    input logic              berr_valid,
    input logic              fpu_valid,
    input logic              exc_enable,
    input logic [ADDR_W-1:0] exc_addr,
    input logic [11:0]       exc_syn,
    input logic [3:0]        fpu_status,
    input logic              exc_req
);

    logic viol;
    logic mis;

    assign viol = stk_check && ((acc_addr < stk_lo) || (acc_addr > stk_hi));
    assign mis  = acc_valid && (acc_mask & acc_addr[1:0]) != 2'b00;

    AST_STACK_ALWAYS_RAISES: assert property (@(posedge clk) disable iff (rst)
        viol |=> (exc_req && exc_syn[4:0] == 5'd7)); // R4

    AST_MISALIGN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (mis && !viol) |=> (exc_addr == $past(acc_addr) && exc_syn[4:0] == 5'd1)); // R2

    AST_MISALIGN_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (mis && !viol && !exc_enable) |=> !exc_req); // R3

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!exc_enable && !stk_check && !acc_valid)
            |=> ($stable(exc_addr) && $stable(exc_syn) && !exc_req)); // R5

    AST_STICKY_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((~fpu_status & $past(fpu_status)) == 4'b0000)); // R7

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> $past(stk_check || acc_valid || berr_valid || fpu_valid)); // R10

endmodule

bind fault_syndrome_unit fault_syndrome_unit_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/fault_syndrome_unit_tb.sv
`timescale 1ns/1ps
module fault_syndrome_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid, acc_write, stk_check;
    logic [AW-1:0] acc_addr, stk_lo, stk_hi, berr_addr;
    logic [1:0]    acc_mask;
    logic [4:0]    acc_rd;
    logic          berr_valid, berr_fetch, fpu_valid;
    logic [3:0]    fpu_flags;
    logic          exc_enable, cfg_ibus_exc, cfg_dbus_exc, cfg_fpu_exc;
    logic [AW-1:0] exc_addr;
    logic [11:0]   exc_syn;
    logic [3:0]    fpu_status;
    logic          exc_req;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    fault_syndrome_unit #(.ADDR_W(AW)) dut_i (.*);

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [AW-1:0] ea,
                           input logic [11:0] es, input logic rq);
        chk(tag, "exc_addr", 64'(exc_addr), 64'(ea));
        chk(tag, "exc_syn",  64'(exc_syn),  64'(es));
        chk(tag, "exc_req",  64'(exc_req),  64'(rq));
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_addr = '0; acc_mask = 2'd0; acc_rd = '0;
        stk_check = 0; berr_valid = 0; berr_fetch = 0; berr_addr = '0;
        fpu_valid = 0; fpu_flags = 4'h0;
    endtask

    // apply stimulus for one cycle; results are visible at the following negedge
    task automatic cycle_end();
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        chk_all("R1", '0, 12'h000, 1'b0);
        chk("R1", "fpu_status", 64'(fpu_status), 64'h0);
    endtask

    task automatic t_misaligned();
        @(negedge clk);
        exc_enable = 1; acc_valid = 1; acc_addr = 32'h1002; acc_mask = 2'd3;
        acc_write = 1; acc_rd = 5'd17;
        cycle_end();
        chk_all("R2", 32'h1002, 12'hE21, 1'b1);
        @(negedge clk);
        chk_all("R10", 32'h1002, 12'hE21, 1'b0);
        exc_enable = 0; acc_valid = 1; acc_addr = 32'h2005; acc_mask = 2'd1;
        acc_write = 0; acc_rd = 5'd3;
        cycle_end();
        chk_all("R3", 32'h2005, 12'h061, 1'b0);
        @(negedge clk);
        exc_enable = 1; acc_valid = 1; acc_addr = 32'h3004; acc_mask = 2'd3; acc_rd = 5'd8;
        cycle_end();
        chk_all("R2", 32'h2005, 12'h061, 1'b0);
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'h3006; acc_mask = 2'd1;
        cycle_end();
        chk_all("R2", 32'h2005, 12'h061, 1'b0);
    endtask

    task automatic t_stack();
        exc_enable = 0; stk_lo = 32'h8000; stk_hi = 32'h8FFF;
        @(negedge clk); stk_check = 1; acc_addr = 32'h8000;
        cycle_end();
        chk_all("R4", 32'h2005, 12'h061, 1'b0);
        @(negedge clk); stk_check = 1; acc_addr = 32'h8FFF;
        cycle_end();
        chk_all("R4", 32'h2005, 12'h061, 1'b0);
        @(negedge clk); stk_check = 1; acc_addr = 32'h7FFC;
        cycle_end();
        chk_all("R4", 32'h7FFC, 12'h007, 1'b1);
        @(negedge clk); stk_check = 1; acc_addr = 32'h9000;
        cycle_end();
        chk_all("R4", 32'h9000, 12'h007, 1'b1);
    endtask

    task automatic t_bus();
        cfg_ibus_exc = 1; cfg_dbus_exc = 1; exc_enable = 0;
        @(negedge clk); berr_valid = 1; berr_fetch = 1; berr_addr = 32'hA000;
        cycle_end();
        chk_all("R5", 32'h9000, 12'h007, 1'b0);
        exc_enable = 1;
        @(negedge clk); berr_valid = 1; berr_fetch = 1; berr_addr = 32'hA000;
        cycle_end();
        chk_all("R6", 32'hA000, 12'h002, 1'b1);
        @(negedge clk); berr_valid = 1; berr_fetch = 0; berr_addr = 32'hB000;
        cycle_end();
        chk_all("R6", 32'hB000, 12'h003, 1'b1);
        cfg_dbus_exc = 0;
        @(negedge clk); berr_valid = 1; berr_fetch = 0; berr_addr = 32'hC000;
        cycle_end();
        chk_all("R6", 32'hC000, 12'h003, 1'b0);
        cfg_dbus_exc = 1;
    endtask

    task automatic t_fpu();
        @(negedge clk); fpu_valid = 0; fpu_flags = 4'hF; cfg_fpu_exc = 1;
        cycle_end();
        chk("R7", "fpu_status", 64'(fpu_status), 64'h0);
        cfg_fpu_exc = 0;
        @(negedge clk); fpu_valid = 1; fpu_flags = 4'h2;
        cycle_end();
        chk("R7", "fpu_status", 64'(fpu_status), 64'h2);
        chk_all("R8", 32'hC000, 12'h003, 1'b0);
        cfg_fpu_exc = 1; exc_enable = 0;
        @(negedge clk); fpu_valid = 1; fpu_flags = 4'h8;
        cycle_end();
        chk("R7", "fpu_status", 64'(fpu_status), 64'hA);
        chk_all("R8", 32'hC000, 12'h003, 1'b0);
        exc_enable = 1;
        @(negedge clk); fpu_valid = 1; fpu_flags = 4'h0;
        cycle_end();
        chk_all("R8", 32'hC000, 12'h003, 1'b0);
        @(negedge clk); fpu_valid = 1; fpu_flags = 4'h8;
        cycle_end();
        chk_all("R8", 32'hC000, 12'h006, 1'b1);
        chk("R7", "fpu_status", 64'(fpu_status), 64'hA);
    endtask

    task automatic t_priority();
        exc_enable = 1; cfg_fpu_exc = 1;
        @(negedge clk);
        stk_check = 1; acc_valid = 1; acc_addr = 32'h101; acc_mask = 2'd1;
        acc_write = 1; acc_rd = 5'd9;
        berr_valid = 1; berr_fetch = 0; berr_addr = 32'hD000;
        fpu_valid = 1; fpu_flags = 4'h1;
        cycle_end();
        chk_all("R9", 32'h101, 12'h007, 1'b1);
        chk("R9", "fpu_status", 64'(fpu_status), 64'hB);
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'h8002; acc_mask = 2'd3; acc_write = 0; acc_rd = 5'd5;
        berr_valid = 1; berr_fetch = 0; berr_addr = 32'hD000;
        fpu_valid = 1; fpu_flags = 4'h4;
        cycle_end();
        chk_all("R9", 32'h8002, 12'h8A1, 1'b1);
        chk("R9", "fpu_status", 64'(fpu_status), 64'hF);
        @(negedge clk);
        berr_valid = 1; berr_fetch = 0; berr_addr = 32'hD000;
        fpu_valid = 1; fpu_flags = 4'h1;
        cycle_end();
        chk_all("R9", 32'hD000, 12'h003, 1'b1);
        @(negedge clk);
        fpu_valid = 1; fpu_flags = 4'h2;
        cycle_end();
        chk_all("R9", 32'hD000, 12'h006, 1'b1);
        @(negedge clk);
        chk_all("R10", 32'hD000, 12'h006, 1'b0);
    endtask

    initial begin
        idle();
        stk_lo = 32'h8000; stk_hi = 32'h8FFF;
        exc_enable = 0; cfg_ibus_exc = 0; cfg_dbus_exc = 0; cfg_fpu_exc = 0;
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_misaligned();
        t_stack();
        t_bus();
        t_fpu();
        t_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule